// File: doc/BRIEF.md
# Serial Command Loader for Multiplexed LED Drivers

This block feeds a daisy chain of multiplexed constant-current LED driver chips over three wires: a shift clock, a data line and a latch line. A host hands it one 16-bit grayscale word at a time on a valid/ready handshake. Each request also carries a latch length N. The block shifts the word out MSB first and raises the latch line for the last N shift-clock pulses of that word. The driver chips decode the command from N alone. A plain data latch uses N=1 and a frame-sync uses N=3. With N=0 the word passes into the chain with no latch at all, which is how words for chips further along the chain are pushed through the nearer ones.

The shift clock idles low and is derived from the system clock by a parameterised divider. Data and latch change only while the shift clock is low, just after each falling edge, and the chips sample them on the rising edge. The chips hold the whole frame, so the host sends words only when the image changes. For one multiplex line that is 48 words per chip, one per output channel across three colour groups of 16. While a word is in flight the block reports busy and refuses new requests. When the last falling edge has gone and the latch has dropped, it pulses done for one cycle.

Top module: `led_serial_loader`

## Requirements
- R1: After reset ser_clk, ser_data, ser_latch and done are 0, busy is 0 and req_ready is 1.
- R2: A request is taken in a cycle where req_valid and req_ready are both 1. From the next cycle busy is 1 and req_ready is 0 until the word is finished. A req_valid raised while busy starts no extra transfer and changes nothing on the serial lines.
- R3: Each accepted word produces exactly 16 rising edges of ser_clk. The ser_data values seen at those edges are the word's bits from bit 15 down to bit 0.
- R4: ser_data and ser_latch change only while ser_clk is low. They hold their values for the whole high phase.
- R5: ser_clk stays high for exactly DIV system cycles per pulse. Between consecutive rising edges of one word it stays low for exactly DIV cycles. The default DIV at a 100 MHz system clock keeps ser_clk at or below 25 MHz.
- R6: With req_lat_len = N in the range 0 to 16, ser_latch is 1 at the last N rising edges of the word and 0 at the earlier ones. N=1 is a data latch, N=3 a frame-sync command, and N=0 gives no latch pulse.
- R7: A req_lat_len above 16 behaves as 16, so ser_latch is 1 at all 16 rising edges.
- R8: ser_latch falls on the same system clock edge as the final falling edge of ser_clk. ser_data also returns to 0 at that edge. Both stay 0 while the block is idle.
- R9: done is 1 for exactly one cycle, on the edge where the final ser_clk fall happens, and busy drops on that same edge. A request held waiting is accepted in that same cycle, so words can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host presents a word |
| req_ready | output | 1 | Block can take a word this cycle |
| req_word | input | DATA_W | Grayscale or command data word |
| req_lat_len | input | CNT_W | Number of final shift pulses with the latch high (0 = none) |
| ser_clk | output | 1 | Serial shift clock, idle low |
| ser_data | output | 1 | Serial data, MSB first |
| ser_latch | output | 1 | Latch line; its high length selects the command |
| busy | output | 1 | A word is being shifted |
| done | output | 1 | One-cycle pulse when a word has finished |

## Verification
The hardest cases to reach from the ports are the edges of the latch window. These are a window that covers the first bit of the word (N=16 and the clamped values above it), a window of zero, and the hand-off where the next word is accepted on the very edge that ends the previous one. Directed requests with lengths 0, 1, 3, 16, 20 and 31 cover the window edges. Random words and lengths, sent as back-to-back pairs with req_valid held high, cover the hand-off. One run also keeps req_valid raised with a different word through a busy period, to show that it starts no extra transfer.

// File: rtl/lsl_pkg.sv
package lsl_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } lsl_state_e;

  // Named latch lengths understood by the driver chips
  localparam int unsigned LAT_NONE       = 0;
  localparam int unsigned LAT_WRITE      = 1;
  localparam int unsigned LAT_FRAME_SYNC = 3;

  // Requested latch length limited to the word width
  function automatic int unsigned lat_clamp(int unsigned n, int unsigned width);
    return (n > width) ? width : n;
  endfunction

  // Latch is high at bit position pos (counted down from width to 1)
  // when that position lies inside the last n bits
  function automatic logic lat_on(int unsigned pos, int unsigned n);
    return (n != 0) && (pos <= n);
  endfunction

endpackage

// File: rtl/lsl_tick_gen.sv
module lsl_tick_gen #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_bypass
      assign tick = run & rst_n;
    end else begin : g_count
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (!run || cnt == LAST) cnt <= '0;
        else                          cnt <= cnt + 1'b1;
      end

      assign tick = run && (cnt == LAST);
    end
  endgenerate

endmodule

// File: rtl/lsl_shift_reg.sv
module lsl_shift_reg #(
  parameter int unsigned W  = 16,
  parameter int unsigned BW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic [W-1:0]  din,
  output logic          msb,
  output logic [BW-1:0] left,
  output logic          last
);

  logic [W-1:0]  sr;
  logic [BW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr     <= '0;
      left_q <= '0;
    end else if (load) begin
      sr     <= din;
      left_q <= BW'(W);
    end else if (advance) begin
      sr     <= {sr[W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign msb  = sr[W-1];
  assign left = left_q;
  assign last = (left_q == BW'(1));

endmodule

// File: rtl/lsl_latch_win.sv
module lsl_latch_win
  import lsl_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 5,
  parameter int unsigned BW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic          finish,
  input  logic [CW-1:0] n_req,
  input  logic [BW-1:0] left,
  output logic          latch
);

  logic [BW-1:0] n_q;
  logic [BW-1:0] n_eff;
  logic [BW-1:0] next_pos;

  assign n_eff    = BW'(lat_clamp(int'(n_req), W));
  assign next_pos = left - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q   <= '0;
      latch <= 1'b0;
    end else if (load) begin
      n_q   <= n_eff;
      latch <= lat_on(W, int'(n_eff));
    end else if (finish) begin
      latch <= 1'b0;
    end else if (advance) begin
      latch <= lat_on(int'(next_pos), int'(n_q));
    end
  end

endmodule

// File: rtl/led_serial_loader.sv
module led_serial_loader
  import lsl_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned DIV    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_word,
  input  logic [CNT_W-1:0]  req_lat_len,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_latch,
  output logic              busy,
  output logic              done
);

  localparam int unsigned BW = $clog2(DATA_W + 1);

  lsl_state_e    state;
  logic          sclk_q;
  logic          done_q;
  logic          tick;
  logic          accept;
  logic          rise_evt;
  logic          fall_evt;
  logic          last_fall;
  logic          step;
  logic          msb;
  logic          last_bit;
  logic [BW-1:0] bits_left;

  assign accept    = req_valid && (state == ST_IDLE);
  assign rise_evt  = tick && !sclk_q;
  assign fall_evt  = tick && sclk_q;
  assign last_fall = fall_evt && last_bit;
  assign step      = fall_evt && !last_bit;

  lsl_tick_gen #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state == ST_SHIFT),
    .tick (tick)
  );

  lsl_shift_reg #(.W(DATA_W), .BW(BW)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .advance(step),
    .din    (req_word),
    .msb    (msb),
    .left   (bits_left),
    .last   (last_bit)
  );

  lsl_latch_win #(.W(DATA_W), .CW(CNT_W), .BW(BW)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .advance(step),
    .finish (last_fall),
    .n_req  (req_lat_len),
    .left   (bits_left),
    .latch  (ser_latch)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_fall;
      if (accept) begin
        state  <= ST_SHIFT;
        sclk_q <= 1'b0;
      end else if (rise_evt) begin
        sclk_q <= 1'b1;
      end else if (fall_evt) begin
        sclk_q <= 1'b0;
        if (last_bit) state <= ST_IDLE;
      end
    end
  end

  assign busy      = (state == ST_SHIFT);
  assign req_ready = !busy;
  assign ser_clk   = sclk_q;
  assign ser_data  = busy && msb;
  assign done      = done_q;

endmodule

// File: rtl/lsl_checker.sv
module lsl_checker #(
  parameter int unsigned DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic accept,
  input logic busy,
  input logic done,
  input logic ser_clk,
  input logic ser_data,
  input logic ser_latch
);

  logic        sclk_d;
  logic [15:0] hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      hold   <= 16'd1;
    end else begin
      sclk_d <= ser_clk;
      if (ser_clk != sclk_d)  hold <= 16'd1;
      else if (hold != '1)    hold <= hold + 16'd1;
    end
  end

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_data && !ser_latch));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  assert_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && sclk_d) |-> ($stable(ser_data) && $stable(ser_latch)));

  assert_high_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_d && !ser_clk) |-> (hold == 16'(DIV)));

  assert_done_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy || $past(accept)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind led_serial_loader lsl_checker #(.DIV(DIV)) u_lsl_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept   (accept),
  .busy     (busy),
  .done     (done),
  .ser_clk  (ser_clk),
  .ser_data (ser_data),
  .ser_latch(ser_latch)
);

// File: tb/tb_led_serial_loader.sv
`timescale 1ns/1ps
module tb_led_serial_loader;

  localparam int unsigned DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_word = '0;
  logic [4:0]  req_lat_len = '0;
  logic        ser_clk, ser_data, ser_latch, busy, done;

  always #5 clk = ~clk;

  led_serial_loader #(.DATA_W(16), .CNT_W(5), .DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_word(req_word), .req_lat_len(req_lat_len), .ser_clk(ser_clk),
    .ser_data(ser_data), .ser_latch(ser_latch), .busy(busy), .done(done)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected latch pattern over the 16 rising edges, first edge in bit 15
  function automatic logic [15:0] exp_mask(input int unsigned n);
    logic [15:0] m = '0;
    int unsigned k = (n > 16) ? 16 : n;
    for (int i = 0; i < 16; i++) if (i < k) m[i] = 1'b1;
    return m;
  endfunction

  // ---------------- port monitor ----------------
  logic        p_sclk = 0, p_sdata = 0, p_slat = 0, p_done = 0;
  int          rises = 0, falls = 0, hi_cnt = 0, lo_cnt = 0;
  int          time_err = 0, stab_err = 0, hs_err = 0, done_err = 0;
  logic [15:0] cap_w = '0, cap_m = '0;
  logic [15:0] res_w[$];
  logic [15:0] res_m[$];
  bit          res_end[$];
  logic [15:0] exp_w[$];
  int unsigned exp_n[$];

  always @(negedge clk) begin
    if (!rst_n) begin
      rises = 0; falls = 0; hi_cnt = 0; lo_cnt = 0;
    end else begin
      if (ser_clk && !p_sclk) begin
        cap_w = {cap_w[14:0], ser_data};
        cap_m = {cap_m[14:0], ser_latch};
        if (rises > 0 && lo_cnt != DIV) time_err++;
        rises++;
        hi_cnt = 1;
      end else if (ser_clk) begin
        hi_cnt++;
        if (ser_data !== p_sdata || ser_latch !== p_slat) stab_err++;
      end else if (p_sclk) begin
        if (hi_cnt != DIV) time_err++;
        falls++;
        lo_cnt = 1;
        if (falls == 16) begin
          res_w.push_back(cap_w);
          res_m.push_back(cap_m);
          res_end.push_back(done && !busy && req_ready && !ser_latch && !ser_data);
          rises = 0;
          falls = 0;
        end
      end else begin
        lo_cnt++;
      end
      if (busy && req_ready) hs_err++;
      if (done && p_done) done_err++;
      if (!busy && (ser_clk || ser_latch || ser_data)) stab_err++;
    end
    p_sclk = ser_clk; p_sdata = ser_data; p_slat = ser_latch; p_done = done;
  end

  // ---------------- stimulus tasks ----------------
  task automatic send(input logic [15:0] w, input int unsigned n);
    @(negedge clk);
    req_valid   = 1'b1;
    req_word    = w;
    req_lat_len = 5'(n);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    exp_w.push_back(w);
    exp_n.push_back(n);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic final_checks();
    chk(res_w.size() == exp_w.size(), "R2 transfer count", res_w.size(), exp_w.size());
    for (int i = 0; i < exp_w.size() && i < res_w.size(); i++) begin
      chk(res_w[i] == exp_w[i], "R3 shifted word", res_w[i], exp_w[i]);
      if (exp_n[i] > 16)
        chk(res_m[i] == exp_mask(exp_n[i]), "R7 clamped latch", res_m[i], exp_mask(exp_n[i]));
      else
        chk(res_m[i] == exp_mask(exp_n[i]), "R6 latch window", res_m[i], exp_mask(exp_n[i]));
      chk(res_end[i], "R8 end of word", res_end[i], 1);
    end
    chk(time_err == 0, "R5 clock timing", time_err, 0);
    chk(stab_err == 0, "R4 data stable high", stab_err, 0);
    chk(hs_err == 0, "R2 ready while busy", hs_err, 0);
    chk(done_err == 0, "R9 done width", done_err, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!ser_clk && !ser_data && !ser_latch && !done, "R1 serial lines idle",
        {ser_clk, ser_data, ser_latch, done}, 0);
    chk(!busy && req_ready, "R1 handshake idle", {busy, req_ready}, 2'b01);

    // R6 directed latch lengths: data latch, frame sync, none, full word
    send(16'hA5C3, 1);  wait_idle();
    send(16'h1234, 3);  wait_idle();
    send(16'hFFFF, 16); wait_idle();
    send(16'h0000, 0);  wait_idle();
    send(16'hFFFF, 0);  wait_idle();
    // R7 lengths above the word width
    send(16'h8001, 20); wait_idle();
    send(16'h7FFE, 31); wait_idle();

    // R2 request raised while busy must not start anything
    send(16'hC0DE, 3);
    @(negedge clk);
    req_valid = 1'b1; req_word = 16'hDEAD; req_lat_len = 5'd1;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (10) @(negedge clk);
    chk(!busy && !ser_clk, "R2 no extra transfer", {busy, ser_clk}, 0);

    // R9 back-to-back: second request waits and is taken on the done edge
    send(16'h0F0F, 1);
    send(16'hF0F0, 3);
    wait_idle();

    // Random words and lengths, singles and back-to-back pairs
    for (int i = 0; i < 40; i++) begin
      send(16'($urandom()), $urandom_range(0, 31));
      if (i % 3 != 0) wait_idle();
    end
    wait_idle();
    repeat (5) @(negedge clk);

    final_checks();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule